// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is one DMA channel that walks a chain of command descriptors held in memory. Each descriptor is fetched one 32-bit word at a time through a simple memory port. It may carry up to fifteen inline control words, which the channel writes into consecutive peripheral register slots. After those writes the channel runs an optional data phase. In that phase words move either from memory to the peripheral or from the peripheral into memory. When the descriptor is done, the channel can raise a completion pulse and decrement its semaphore. It then follows the link to the next descriptor, or stops.

Software arms the channel by writing the descriptor address while the channel is idle, and starts it by incrementing the semaphore. The channel can be frozen at any point and resumed with no loss of state. It can also be reset back to idle. A bus error or a halting terminate request raises an error pulse, and the channel then stays halted until it is reset.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset or a `sw_chan_rst` pulse the channel is idle: `sema_count` is 0 and `mem_req`, `tx_valid`, `rx_ready`, `pio_we`, `done_irq` and `err_irq` are low.
- R2: No memory access starts while `sema_count` is 0, even after a descriptor address has been written.
- R3: A descriptor at address A is read as consecutive words: A holds the next-descriptor address; A+4 holds the control half in bits 15:0 and the byte count in bits 31:16; A+8 holds the buffer address; the inline words follow from A+12 on. The number of inline words is control bits 15:12.
- R4: Inline word k (k = 0 upward) is written to peripheral slot k through `pio_we`/`pio_idx`/`pio_data`, and every such write comes before any data-phase handshake of the same descriptor.
- R5: Control bits 1:0 select the operation. Value 2 reads memory and sends the words to the peripheral. Value 1 takes words from the peripheral and writes them to memory. Values 0 and 3 move no data. The data phase handles ceil(count/4) words at the buffer address plus 4 per word.
- R6: With control bit 2 (link) clear, the channel goes idle after the descriptor. A later semaphore increment does not restart it until a new descriptor address is written.
- R7: Control bit 3 gives a one-cycle `done_irq` at completion, and control bit 6 decrements the semaphore there. A linked descriptor whose decrement brings the count to 0 stops the channel. The next increment resumes it at the linked address.
- R8: With control bit 7 set, completion waits for a `per_end` pulse.
- R9: During a data phase, `per_term` with control bit 8 set aborts the descriptor with a one-cycle `err_irq` and no completion. With bit 8 clear, `per_term` is ignored.
- R10: A memory error response raises `err_irq`. After an error or an abort, the channel makes no access until `sw_chan_rst`, and semaphore increments do not restart it.
- R11: While `sw_freeze` is high, no handshake or memory request is issued and no state advances. Lowering it resumes the channel at the same point.
- R12: A byte count of 0xFF00 moves exactly 16320 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_addr_we | input | 1 | Write strobe for the descriptor address (taken only when idle) |
| sw_addr | input | 32 | Descriptor address value |
| sw_sema_inc | input | 1 | Adds one to the semaphore |
| sw_freeze | input | 1 | Holds the channel in place |
| sw_chan_rst | input | 1 | Aborts the channel and clears the semaphore |
| sema_count | output | 8 | Current semaphore count |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_err | input | 1 | Error response together with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| pio_we | output | 1 | Peripheral register write |
| pio_idx | output | 4 | Peripheral register slot |
| pio_data | output | 32 | Peripheral register value |
| tx_valid | output | 1 | Word offered to the peripheral |
| tx_data | output | 32 | Word to the peripheral |
| tx_ready | input | 1 | Peripheral accepts the word |
| rx_valid | input | 1 | Peripheral offers a word |
| rx_data | input | 32 | Word from the peripheral |
| rx_ready | output | 1 | Channel accepts the word |
| per_end | input | 1 | End-of-command from the peripheral |
| per_term | input | 1 | Terminate request from the peripheral |
| done_irq | output | 1 | Completion pulse |
| err_irq | output | 1 | Error or abort pulse |

## Verification
The bench runs a two-descriptor chain and checks the order of the fetch addresses. A design that mis-sized the inline-word list would read too far or too little, and would also shift the data buffer reads. It stops a linked chain by semaphore exhaustion and then resumes it, which catches a design that keeps running at zero or forgets the linked address. It freezes the channel in the middle of a peripheral stall, and it sends terminates with and without the halt bit; a wrong design would leak handshakes, or would abort when it should not. It also runs a bus error and the largest byte count, where an overflow in the rounding of the word count would cut the transfer short.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int XIDX_W = 15;  // word index inside one data phase
  localparam int WIDX_W = 5;   // word index inside one descriptor

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_MRD, ST_PTX, ST_PRX, ST_MWR, ST_WEND, ST_COMPL, ST_HALT
  } seq_state_t;

  localparam logic [1:0] OP_TO_MEM   = 2'd1;
  localparam logic [1:0] OP_FROM_MEM = 2'd2;

  // ceil(bytes/4) without overflowing the 16-bit count
  function automatic logic [XIDX_W-1:0] words_of(input logic [15:0] bytes);
    logic [16:0] sum;
    sum = {1'b0, bytes} + 17'd3;
    return sum[16:2];
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [15:0] idx);
    return base + ADDR_W'({idx, 2'b00});
  endfunction

  function automatic seq_state_t data_entry(input logic [1:0] op,
                                            input logic [XIDX_W-1:0] words);
    if (words == '0)          return ST_WEND;
    else if (op == OP_FROM_MEM) return ST_MRD;
    else if (op == OP_TO_MEM)   return ST_PRX;
    else                        return ST_WEND;
  endfunction
endpackage

// File: rtl/dma_sema_ctr.sv
module dma_sema_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_next
);
  logic [W-1:0] step_val;

  always_comb begin
    step_val = cnt;
    case ({inc, dec})
      2'b10: if (cnt != '1) step_val = cnt + 1'b1;
      2'b01: if (cnt != '0) step_val = cnt - 1'b1;
      default: step_val = cnt;
    endcase
    cnt_next = clr ? '0 : step_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_next;
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_seq_pkg::*;
(
  input  logic              use_desc,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [WIDX_W-1:0] widx,
  input  logic [ADDR_W-1:0] buf_base,
  input  logic [XIDX_W-1:0] xidx,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    if (use_desc) addr = word_addr(desc_base, 16'(widx));
    else          addr = word_addr(buf_base, 16'(xidx));
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_seq_pkg::*;
#(
  parameter int SEM_W     = 8,
  parameter int PIO_SLOTS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_addr_we,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic              sw_sema_inc,
  input  logic              sw_freeze,
  input  logic              sw_chan_rst,
  output logic [SEM_W-1:0]  sema_count,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              pio_we,
  output logic [$clog2(PIO_SLOTS)-1:0] pio_idx,
  output logic [WORD_W-1:0] pio_data,
  output logic              tx_valid,
  output logic [WORD_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              per_end,
  input  logic              per_term,
  output logic              done_irq,
  output logic              err_irq
);
  localparam int PIO_IDX_W = $clog2(PIO_SLOTS);
  localparam logic [WIDX_W-1:0] HDR_WORDS = WIDX_W'(3);

  seq_state_t        state_q;
  logic [ADDR_W-1:0] desc_q, nxt_q, buf_q;
  logic [1:0]        op_q;
  logic              link_q, irq_q, dec_q, wend_q, halt_q, armed_q;
  logic [3:0]        npio_q;
  logic [15:0]       bytes_q;
  logic [WIDX_W-1:0] widx_q;
  logic [XIDX_W-1:0] xidx_q;
  logic [WORD_W-1:0] hold_q;
  logic [SEM_W-1:0]  sema_next;

  // named internal events
  logic run, mem_acc, evt_berr, evt_term, evt_pio, evt_compl, evt_start, fetch_last, data_last;
  logic [XIDX_W-1:0] words;

  assign run       = !sw_freeze;
  assign words     = words_of(bytes_q);
  assign mem_req   = run && (state_q == ST_FETCH || state_q == ST_MRD || state_q == ST_MWR);
  assign mem_we    = (state_q == ST_MWR);
  assign mem_wdata = hold_q;
  assign mem_acc   = mem_req && mem_ack;
  assign evt_berr  = mem_acc && mem_err;
  assign evt_term  = run && per_term && halt_q && (state_q == ST_PTX || state_q == ST_PRX);
  assign evt_pio   = mem_acc && !mem_err && (state_q == ST_FETCH) && (widx_q >= HDR_WORDS);
  assign evt_compl = run && (state_q == ST_COMPL);
  assign evt_start = run && (state_q == ST_IDLE) && !sw_addr_we && armed_q && (sema_count != '0);
  assign fetch_last = (widx_q >= WIDX_W'(2)) && (widx_q == {1'b0, npio_q} + WIDX_W'(2));
  assign data_last  = (xidx_q + XIDX_W'(1)) == words;

  assign pio_we   = evt_pio;
  assign pio_idx  = PIO_IDX_W'(widx_q - HDR_WORDS);
  assign pio_data = mem_rdata;
  assign tx_valid = run && (state_q == ST_PTX);
  assign tx_data  = hold_q;
  assign rx_ready = run && (state_q == ST_PRX);
  assign done_irq = evt_compl && irq_q;
  assign err_irq  = evt_berr || evt_term;

  dma_sema_ctr #(.W(SEM_W)) u_sema (
    .clk(clk), .rst_n(rst_n), .clr(sw_chan_rst), .inc(sw_sema_inc),
    .dec(evt_compl && dec_q), .cnt(sema_count), .cnt_next(sema_next)
  );

  dma_addr_gen u_addr (
    .use_desc(state_q == ST_FETCH), .desc_base(desc_q), .widx(widx_q),
    .buf_base(buf_q), .xidx(xidx_q), .addr(mem_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      desc_q <= '0; nxt_q <= '0; buf_q <= '0; hold_q <= '0;
      op_q <= '0; link_q <= 1'b0; irq_q <= 1'b0; dec_q <= 1'b0;
      wend_q <= 1'b0; halt_q <= 1'b0; npio_q <= '0; bytes_q <= '0;
      widx_q <= '0; xidx_q <= '0; armed_q <= 1'b0;
    end else if (sw_chan_rst) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (sw_addr_we) begin
            desc_q  <= sw_addr;
            armed_q <= 1'b1;
          end else if (evt_start) begin
            state_q <= ST_FETCH;
            widx_q  <= '0;
          end
        end
        ST_FETCH: if (mem_acc) begin
          if (mem_err) state_q <= ST_HALT;
          else begin
            case (widx_q)
              WIDX_W'(0): nxt_q <= mem_rdata;
              WIDX_W'(1): begin
                op_q   <= mem_rdata[1:0];  link_q <= mem_rdata[2];
                irq_q  <= mem_rdata[3];    dec_q  <= mem_rdata[6];
                wend_q <= mem_rdata[7];    halt_q <= mem_rdata[8];
                npio_q <= mem_rdata[15:12]; bytes_q <= mem_rdata[31:16];
              end
              WIDX_W'(2): buf_q <= mem_rdata;
              default: ;
            endcase
            if (fetch_last) begin
              xidx_q  <= '0;
              state_q <= data_entry(op_q, words);
            end else widx_q <= widx_q + 1'b1;
          end
        end
        ST_MRD: if (mem_acc) begin
          if (mem_err) state_q <= ST_HALT;
          else begin hold_q <= mem_rdata; state_q <= ST_PTX; end
        end
        ST_PTX: begin
          if (evt_term) state_q <= ST_HALT;
          else if (run && tx_ready) begin
            xidx_q  <= xidx_q + 1'b1;
            state_q <= data_last ? ST_WEND : ST_MRD;
          end
        end
        ST_PRX: begin
          if (evt_term) state_q <= ST_HALT;
          else if (run && rx_valid) begin
            hold_q  <= rx_data;
            state_q <= ST_MWR;
          end
        end
        ST_MWR: if (mem_acc) begin
          if (mem_err) state_q <= ST_HALT;
          else begin
            xidx_q  <= xidx_q + 1'b1;
            state_q <= data_last ? ST_WEND : ST_PRX;
          end
        end
        ST_WEND: if (run && (!wend_q || per_end)) state_q <= ST_COMPL;
        ST_COMPL: if (run) begin
          if (link_q) begin
            desc_q <= nxt_q;
            if (sema_next != '0) begin
              state_q <= ST_FETCH;
              widx_q  <= '0;
            end else state_q <= ST_IDLE;
          end else begin
            state_q <= ST_IDLE;
            armed_q <= 1'b0;
          end
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter int SEM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_chan_rst,
  input logic             sw_freeze,
  input logic             mem_req,
  input logic             tx_valid,
  input logic             rx_ready,
  input logic             pio_we,
  input logic             done_irq,
  input logic             err_irq,
  input logic [SEM_W-1:0] sema_count
);
  AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_chan_rst) |-> (sema_count == '0 && !mem_req && !tx_valid && !rx_ready)); // R1

  AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sw_freeze |-> (!mem_req && !tx_valid && !rx_ready && !pio_we && !done_irq)); // R11

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, tx_valid, rx_ready})); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R7

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !mem_req); // R10

  AST_SEMA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sw_chan_rst) |-> (sema_count == $past(sema_count) ||
                             sema_count == $past(sema_count) + 1'b1 ||
                             sema_count == $past(sema_count) - 1'b1)); // R7
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.SEM_W(SEM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_chan_rst(sw_chan_rst), .sw_freeze(sw_freeze),
  .mem_req(mem_req), .tx_valid(tx_valid), .rx_ready(rx_ready), .pio_we(pio_we),
  .done_irq(done_irq), .err_irq(err_irq), .sema_count(sema_count)
);

// File: tb/dma_chain_seq_tb_top.sv
module dma_chain_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        sw_addr_we = 0, sw_sema_inc = 0, sw_freeze = 0, sw_chan_rst = 0;
  logic [31:0] sw_addr = 0;
  logic [7:0]  sema_count;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        pio_we;
  logic [3:0]  pio_idx;
  logic [31:0] pio_data, tx_data;
  logic        tx_valid, rx_ready, done_irq, err_irq;
  logic        tx_ready = 1, rx_valid = 0, per_end = 0, per_term = 0;
  logic [31:0] rx_word = 32'h5000_0000;

  logic [31:0] mem [0:1023];
  assign mem_ack   = mem_req;
  assign mem_err   = mem_req && (mem_addr[31:16] != 16'h0);
  assign mem_rdata = mem[mem_addr[11:2]];

  dma_chain_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sw_addr_we(sw_addr_we), .sw_addr(sw_addr),
    .sw_sema_inc(sw_sema_inc), .sw_freeze(sw_freeze), .sw_chan_rst(sw_chan_rst),
    .sema_count(sema_count), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .pio_we(pio_we), .pio_idx(pio_idx), .pio_data(pio_data), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_word),
    .rx_ready(rx_ready), .per_end(per_end), .per_term(per_term),
    .done_irq(done_irq), .err_irq(err_irq)
  );

  int total = 0, fails = 0;
  int done_cnt = 0, err_cnt = 0, tx_total = 0, pio_seen = 0, pio_at_first_tx = -1;
  bit rx_adv = 0, finished = 0;
  logic [35:0] exp_pio[$];
  logic [31:0] exp_tx[$];
  logic [63:0] exp_wr[$];
  logic [31:0] rd_log[$];
  logic [31:0] rx_pred = 32'h5000_0000;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference observer: every event at the ports is compared with the model's queues.
  always @(negedge clk) if (rst_n) begin
    if (pio_we) begin
      if (exp_pio.size() == 0) chk(0, "R4", {pio_idx, pio_data}, 0);
      else begin
        logic [35:0] e;
        e = exp_pio.pop_front();
        chk({pio_idx, pio_data} == e, "R4", {pio_idx, pio_data}, e);
      end
      pio_seen++;
    end
    if (tx_valid && tx_ready) begin
      if (tx_total == 0) pio_at_first_tx = pio_seen;
      if (exp_tx.size() == 0) chk(0, "R5", tx_data, 0);
      else begin
        logic [31:0] e;
        e = exp_tx.pop_front();
        chk(tx_data == e, "R5", tx_data, e);
      end
      tx_total++;
    end
    if (mem_req && mem_ack && !mem_err && !mem_we) rd_log.push_back(mem_addr);
    if (mem_req && mem_ack && !mem_err && mem_we) begin
      if (exp_wr.size() == 0) chk(0, "R5", {mem_addr, mem_wdata}, 0);
      else begin
        logic [63:0] e;
        e = exp_wr.pop_front();
        chk({mem_addr, mem_wdata} == e, "R5", {mem_addr, mem_wdata}, e);
      end
      mem[mem_addr[11:2]] = mem_wdata;
    end
    if (rx_valid && rx_ready) rx_adv = 1;
    if (done_irq) done_cnt++;
    if (err_irq) err_cnt++;
  end

  always @(posedge clk) begin
    #1;
    if (rx_adv) begin rx_word = rx_word + 32'h11; rx_adv = 0; end
  end

  task automatic step(); @(posedge clk); #2; endtask
  task automatic idle(input int n); repeat (n) step(); endtask
  task automatic wait_done(input int target, input int lim);
    for (int k = 0; k < lim && done_cnt < target; k++) step();
  endtask
  task automatic write_addr(input logic [31:0] a);
    sw_addr = a; sw_addr_we = 1; step(); sw_addr_we = 0;
  endtask
  task automatic sema_up(); sw_sema_inc = 1; step(); sw_sema_inc = 0; endtask
  task automatic chan_reset(); sw_chan_rst = 1; step(); sw_chan_rst = 0; endtask

  function automatic logic [15:0] mk_ctl(input logic [1:0] op, input bit lnk, input bit irq,
      input bit dec, input bit wend, input bit halt, input logic [3:0] npio);
    return {npio, 2'b00, 1'b0, halt, wend, dec, 2'b00, irq, lnk, op};
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [15:0] ctl,
      input logic [15:0] bytes, input logic [31:0] bufa);
    mem[a[11:2]]      = nxt;
    mem[a[11:2] + 1]  = {bytes, ctl};
    mem[a[11:2] + 2]  = bufa;
  endtask

  task automatic expect_rx(input logic [31:0] bufa, input int n);
    for (int i = 0; i < n; i++) begin
      exp_wr.push_back({bufa + 32'(i * 4), rx_pred});
      rx_pred = rx_pred + 32'h11;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int s, r;
    logic [31:0] exp_rd[$];
    for (int i = 0; i < 1024; i++) mem[i] = 32'h1357_0000 ^ (i * 32'h0101_0001);
    idle(3);
    rst_n = 1;
    step();
    // R1: reset state
    chk(sema_count == 0 && !mem_req && !tx_valid && !rx_ready && !pio_we && !done_irq && !err_irq,
        "R1", {sema_count, mem_req, tx_valid, rx_ready}, 0);

    // Scenario A: two linked descriptors, inline words, both data directions
    put_desc(32'h100, 32'h140, mk_ctl(2'd2, 1, 1, 0, 0, 0, 4'd2), 16'd10, 32'h200);
    mem[32'h10C >> 2] = 32'hA0A0_0001;
    mem[32'h110 >> 2] = 32'hA0A0_0002;
    put_desc(32'h140, 32'h0, mk_ctl(2'd1, 0, 1, 1, 0, 1, 4'd0), 16'd8, 32'h300);
    exp_pio.push_back({4'd0, 32'hA0A0_0001});
    exp_pio.push_back({4'd1, 32'hA0A0_0002});
    for (int i = 0; i < 3; i++) exp_tx.push_back(mem[(32'h200 >> 2) + i]);
    expect_rx(32'h300, 2);
    rx_valid = 1;
    write_addr(32'h100);
    idle(20);
    chk(rd_log.size() == 0, "R2", rd_log.size(), 0);
    sema_up();
    wait_done(2, 300);
    idle(5);
    rx_valid = 0;
    exp_rd = '{32'h100, 32'h104, 32'h108, 32'h10C, 32'h110, 32'h200, 32'h204, 32'h208,
               32'h140, 32'h144, 32'h148};
    chk(rd_log.size() == exp_rd.size(), "R3", rd_log.size(), exp_rd.size());
    for (int i = 0; i < exp_rd.size() && i < rd_log.size(); i++)
      chk(rd_log[i] == exp_rd[i], "R3", rd_log[i], exp_rd[i]);
    chk(exp_pio.size() == 0 && pio_at_first_tx == 2, "R4", pio_at_first_tx, 2);
    chk(exp_tx.size() == 0 && exp_wr.size() == 0, "R5", exp_tx.size() + exp_wr.size(), 0);
    chk(done_cnt == 2, "R7", done_cnt, 2);
    chk(sema_count == 0, "R7", sema_count, 0);

    // R6: link clear leaves the channel unarmed
    sema_up();
    idle(20);
    chk(rd_log.size() == 11, "R6", rd_log.size(), 11);

    // Scenario B: semaphore exhaustion on a link, resume, end-of-command wait
    put_desc(32'h180, 32'h1C0, mk_ctl(2'd3, 1, 1, 1, 0, 0, 4'd0), 16'h20, 32'h200);
    put_desc(32'h1C0, 32'h0, mk_ctl(2'd0, 0, 1, 1, 1, 0, 4'd0), 16'h20, 32'h200);
    rd_log.delete();
    write_addr(32'h180);
    idle(20);
    chk(done_cnt == 3 && sema_count == 0, "R7", {done_cnt, sema_count}, {32'd3, 8'd0});
    chk(rd_log.size() == 3, "R5", rd_log.size(), 3);
    sema_up();
    idle(15);
    chk(rd_log.size() == 6 && rd_log[3] == 32'h1C0, "R7", rd_log.size(), 6);
    chk(done_cnt == 3, "R8", done_cnt, 3);
    per_end = 1; step(); per_end = 0;
    idle(3);
    chk(done_cnt == 4, "R8", done_cnt, 4);

    // Scenario C: freeze during a peripheral stall
    put_desc(32'h240, 32'h0, mk_ctl(2'd2, 0, 1, 1, 0, 0, 4'd0), 16'd16, 32'h280);
    for (int i = 0; i < 4; i++) exp_tx.push_back(mem[(32'h280 >> 2) + i]);
    tx_ready = 0;
    write_addr(32'h240);
    sema_up();
    idle(12);
    sw_freeze = 1;
    tx_ready = 1;
    s = tx_total; r = rd_log.size();
    idle(10);
    chk(tx_total == s && rd_log.size() == r, "R11", tx_total - s, 0);
    chk(done_cnt == 4, "R11", done_cnt, 4);
    sw_freeze = 0;
    wait_done(5, 100);
    idle(2);
    chk(exp_tx.size() == 0 && done_cnt == 5, "R11", exp_tx.size(), 0);

    // Scenario D: terminate without the halt bit is ignored
    put_desc(32'h2C0, 32'h0, mk_ctl(2'd1, 0, 1, 1, 0, 0, 4'd0), 16'd4, 32'h340);
    expect_rx(32'h340, 1);
    write_addr(32'h2C0);
    sema_up();
    idle(10);
    per_term = 1; step(); per_term = 0;
    idle(3);
    chk(err_cnt == 0, "R9", err_cnt, 0);
    rx_valid = 1;
    wait_done(6, 50);
    idle(2);
    rx_valid = 0;
    chk(done_cnt == 6 && exp_wr.size() == 0, "R9", done_cnt, 6);

    // Scenario E: terminate with the halt bit aborts and halts
    put_desc(32'h380, 32'h0, mk_ctl(2'd1, 0, 1, 1, 0, 1, 4'd0), 16'd4, 32'h3C0);
    write_addr(32'h380);
    sema_up();
    idle(10);
    per_term = 1; step(); per_term = 0;
    idle(2);
    chk(err_cnt == 1 && done_cnt == 6, "R9", {err_cnt, done_cnt}, {32'd1, 32'd6});
    r = rd_log.size();
    sema_up();
    idle(20);
    chk(rd_log.size() == r, "R10", rd_log.size(), r);
    chan_reset();
    idle(2);
    chk(sema_count == 0 && !mem_req, "R1", sema_count, 0);

    // Scenario F: bus error on descriptor fetch
    write_addr(32'h0001_0000);
    sema_up();
    idle(5);
    chk(err_cnt == 2, "R10", err_cnt, 2);
    r = rd_log.size();
    sema_up();
    idle(10);
    chk(rd_log.size() == r && done_cnt == 6, "R10", rd_log.size(), r);
    chan_reset();
    idle(2);

    // Scenario G: largest byte count
    put_desc(32'h3E0, 32'h0, mk_ctl(2'd2, 0, 1, 1, 0, 0, 4'd0), 16'hFF00, 32'h0);
    for (int i = 0; i < 16320; i++) exp_tx.push_back(mem[i % 1024]);
    s = tx_total;
    write_addr(32'h3E0);
    sema_up();
    wait_done(7, 40000);
    idle(2);
    chk(tx_total - s == 16320, "R12", tx_total - s, 16320);
    chk(exp_tx.size() == 0 && done_cnt == 7, "R12", exp_tx.size(), 0);

    summary();
  end
endmodule